// File: doc/BRIEF.md
# Soft-Decision Branch Metric Unit

This block sits at the front of a Viterbi decoder for a rate 1/N convolutional code. Each cycle it can take one received group of N quantized soft values. From that group it produces a distance metric for every one of the 2^N code-word labels that a trellis branch can carry. The add-compare-select stage then picks, for each trellis state, the best of the branches that enter it. Soft values are offset-binary confidence levels on B bits. A value of 0 means a zero received with full confidence, and 2^B-1 means a one received with full confidence. Hard decisions are simply the case B=1.

Some positions in a group carry no usable information, so they must not bias the metric. The caller marks such positions in two ways. A per-cycle erasure mask flags positions that were erased in the channel. A static keep pattern flags positions removed by puncturing at the transmitter. Either kind of position is left out of every label's sum.

Each soft lane is carried in a container of INW bits, which may be wider than B. A value that does not fit in B bits is clipped to the strongest one, and it raises a range flag in the same cycle as the results it affects.

Top module: `soft_branch_metric`

## Requirements
- R1: For a label whose expected bit on lane i is 0, lane i adds its soft value v to that label's metric. Label j expects bit i of j on lane i. Lane i is soft_in[i*INW +: INW], and label j's metric is metrics[j*MW +: MW], with MW = B+N-1.
- R2: For a label whose expected bit on lane i is 1, lane i adds (2^B-1)-v. As a result, label 0 and label 2^N-1 always sum to (2^B-1) times the number of active lanes.
- R3: Each label's metric is the unsigned sum of its per-lane distances over the active lanes. For every input pattern it is exact in MW bits.
- R4: A lane with erase_in[i]=1 adds nothing to any metric. If every lane is inactive, all metrics are 0.
- R5: A lane with punct_keep[i]=0 is punctured and is excluded from every metric exactly as an erased lane is.
- R6: With B=1 each metric equals the Hamming distance between the received bits and the label, counted over the active lanes.
- R7: out_valid is high exactly in the cycle after a cycle with in_valid high. The metrics of that input appear in the same cycle.
- R8: While in_valid is low, metrics keep their previous values and out_valid is low, whatever the other inputs do.
- R9: A lane value above 2^B-1 is used as 2^B-1. range_err is high together with out_valid for an input in which any lane exceeded 2^B-1, and low otherwise.
- R10: After reset, out_valid, range_err and all metrics are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input group is valid this cycle |
| soft_in | input | N*INW | N soft lanes, lane i at bits i*INW |
| erase_in | input | N | 1 = lane erased this cycle |
| punct_keep | input | N | Static pattern, 0 = lane punctured |
| out_valid | output | 1 | Metrics updated from the previous cycle's input |
| metrics | output | 2^N*(B+N-1) | Branch metric per label, label j at bits j*MW |
| range_err | output | 1 | A lane of the reported input was out of range |

## Verification
A wrong lane mask, or a swapped distance polarity, shows up in the metric bus in the first cycle after the faulty input. The check against a model of the per-lane sums catches it there, and so does the check that label 0 and the all-ones label add up to a fixed total. A wrong hold or valid register shows up one cycle later. In that case either out_valid disagrees with the delayed in_valid, or the metrics move while no input is valid. A clipping fault only shows when an oversized container value is applied, and it shows in both the metrics and range_err of the next cycle.

// File: rtl/soft_branch_metric.sv
module soft_branch_metric #(
  parameter int N   = 2,
  parameter int B   = 3,
  parameter int INW = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [N*INW-1:0]              soft_in,
  input  logic [N-1:0]                  erase_in,
  input  logic [N-1:0]                  punct_keep,
  output logic                          out_valid,
  output logic [(1<<N)*(B+N-1)-1:0]     metrics,
  output logic                          range_err
);
  localparam int NLAB = 1 << N;
  localparam int MW   = B + N - 1;
  localparam logic [B-1:0] VMAX = {B{1'b1}};

  logic [B-1:0]  lane_v [N];
  logic [N-1:0]  act;
  logic [N-1:0]  ovr;
  logic [MW-1:0] sum_c  [NLAB];

  for (genvar gi = 0; gi < N; gi++) begin : g_lane
    logic [INW-1:0] raw;
    assign raw = soft_in[gi*INW +: INW];
    if (INW > B) begin : g_chk
      assign ovr[gi] = |raw[INW-1:B];
    end else begin : g_nochk
      assign ovr[gi] = 1'b0;
    end
    assign lane_v[gi] = ovr[gi] ? VMAX : raw[B-1:0];
    assign act[gi]    = punct_keep[gi] & ~erase_in[gi];
  end

  always_comb begin
    for (int j = 0; j < NLAB; j++) begin
      sum_c[j] = '0;
      for (int i = 0; i < N; i++) begin
        if (act[i]) begin
          if (((j >> i) & 1) == 1)
            sum_c[j] = sum_c[j] + MW'(VMAX - lane_v[i]);
          else
            sum_c[j] = sum_c[j] + MW'(lane_v[i]);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      range_err <= 1'b0;
      metrics   <= '0;
    end else begin
      out_valid <= in_valid;
      range_err <= in_valid & (|ovr);
      if (in_valid) begin
        for (int j = 0; j < NLAB; j++)
          metrics[j*MW +: MW] <= sum_c[j];
      end
    end
  end

  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(metrics));
  assert_flag_with_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |-> out_valid);
  assert_all_inactive_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && act == '0) |=> metrics == '0);
  assert_label_pair_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (32'(metrics[MW-1:0]) + 32'(metrics[NLAB*MW-1 -: MW]))
                  == $countones($past(act)) * 32'(VMAX));
endmodule

// File: tb/soft_branch_metric_test.sv
module soft_branch_metric_test;
  localparam int N = 2, B = 3, INW = 4;
  localparam int NL = 1 << N, MW = B + N - 1, VMAX = (1 << B) - 1;
  localparam int HN = 3, HMW = 3, HNL = 8;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [N*INW-1:0] soft_in = '0;
  logic [N-1:0] erase_in = '0, punct_keep = '1;
  logic out_valid, range_err;
  logic [NL*MW-1:0] metrics;

  logic h_valid = 0;
  logic [HN-1:0] h_in = '0, h_er = '0, h_keep = '1;
  logic h_ov, h_re;
  logic [HNL*HMW-1:0] h_met;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  soft_branch_metric #(.N(N), .B(B), .INW(INW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .soft_in(soft_in),
    .erase_in(erase_in), .punct_keep(punct_keep), .out_valid(out_valid),
    .metrics(metrics), .range_err(range_err));

  soft_branch_metric #(.N(HN), .B(1), .INW(1)) uut_hd (
    .clk(clk), .rst_n(rst_n), .in_valid(h_valid), .soft_in(h_in),
    .erase_in(h_er), .punct_keep(h_keep), .out_valid(h_ov),
    .metrics(h_met), .range_err(h_re));

  function automatic logic [NL*MW-1:0] ref_bus(input logic [N*INW-1:0] s,
      input logic [N-1:0] er, input logic [N-1:0] kp);
    logic [NL*MW-1:0] r;
    r = '0;
    for (int j = 0; j < NL; j++) begin
      int acc;
      acc = 0;
      for (int i = 0; i < N; i++) begin
        int v;
        v = int'(s[i*INW +: INW]);
        if (v > VMAX) v = VMAX;
        if (kp[i] && !er[i]) acc += ((j >> i) & 1) ? VMAX - v : v;
      end
      r[j*MW +: MW] = MW'(acc);
    end
    return r;
  endfunction

  function automatic logic [HNL*HMW-1:0] ref_ham(input logic [HN-1:0] x,
      input logic [HN-1:0] er);
    logic [HNL*HMW-1:0] r;
    r = '0;
    for (int j = 0; j < HNL; j++) begin
      int d;
      d = 0;
      for (int i = 0; i < HN; i++)
        if (!er[i] && (x[i] != j[i])) d++;
      r[j*HMW +: HMW] = HMW'(d);
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input string tag, input logic [N*INW-1:0] s,
      input logic [N-1:0] er, input logic [N-1:0] kp, input logic exp_re);
    @(negedge clk);
    soft_in = s; erase_in = er; punct_keep = kp; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    chk(tag, 64'(metrics), 64'(ref_bus(s, er, kp)));
    chk({tag, " valid R7"}, 64'(out_valid), 64'd1);
    chk({tag, " flag R9"}, 64'(range_err), 64'(exp_re));
  endtask

  initial begin
    logic [NL*MW-1:0] held;
    repeat (3) @(negedge clk);
    chk("R10 out_valid", 64'(out_valid), 0);
    chk("R10 range_err", 64'(range_err), 0);
    chk("R10 metrics", 64'(metrics), 0);
    rst_n = 1;

    send("R1 all zero", {4'd0, 4'd0}, 2'b00, 2'b11, 0);
    send("R2 all max", {4'd7, 4'd7}, 2'b00, 2'b11, 0);
    send("R3 mixed", {4'd5, 4'd2}, 2'b00, 2'b11, 0);
    send("R3 weak levels", {4'd4, 4'd3}, 2'b00, 2'b11, 0);
    send("R4 erase lane0", {4'd6, 4'd1}, 2'b01, 2'b11, 0);
    send("R4 erase both", {4'd6, 4'd1}, 2'b11, 2'b11, 0);
    send("R5 puncture lane1", {4'd6, 4'd1}, 2'b00, 2'b01, 0);
    send("R5 punct+erase", {4'd2, 4'd5}, 2'b10, 2'b10, 0);
    send("R9 over range", {4'd3, 4'd12}, 2'b00, 2'b11, 1);
    send("R9 over on erased lane", {4'd15, 4'd1}, 2'b10, 2'b11, 1);

    held = metrics;
    @(negedge clk);
    soft_in = {4'd1, 4'd6}; erase_in = 2'b00; punct_keep = 2'b11; in_valid = 0;
    @(negedge clk);
    chk("R8 hold metrics", 64'(metrics), 64'(held));
    chk("R8 valid low", 64'(out_valid), 0);
    chk("R8 flag low", 64'(range_err), 0);

    for (int k = 0; k < 200; k++) begin
      logic [N*INW-1:0] s;
      logic [N-1:0] er, kp;
      logic ov;
      s = N*INW'($urandom);
      er = N'($urandom) & N'($urandom);
      kp = N'($urandom) | N'($urandom);
      ov = 0;
      for (int i = 0; i < N; i++) if (s[i*INW +: INW] > VMAX) ov = 1;
      send("R3 random", s, er, kp, ov);
    end

    for (int k = 0; k < 16; k++) begin
      logic [HN-1:0] x, er;
      x = HN'($urandom);
      er = (k < 8) ? '0 : HN'($urandom);
      @(negedge clk);
      h_in = x; h_er = er; h_valid = 1;
      @(negedge clk);
      h_valid = 0;
      chk("R6 hamming", 64'(h_met), 64'(ref_ham(x, er)));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #(8 * 20000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule